// File: doc/BRIEF.md
# Load-Store Byte Lane Aligner

This unit sits between the integer datapath of a 32-bit processor and a word-wide data memory that is addressed by byte. On a load it takes the full word read from memory, picks out the byte or halfword named by the low address bits, and sign- or zero-extends it into a register value. On a store it copies the register's byte or halfword onto the memory data lanes and raises only the byte write enables that belong to the access, so the other bytes of the word keep their contents. It also forms the result of load-upper-immediate from a 16-bit immediate.

Lanes are big-endian: address offset 0 names bits 31:24 and offset 3 names bits 7:0. A halfword access at an odd offset, or a word access at any nonzero offset, is flagged as misaligned and writes no byte. The caller supplies the already computed effective address, which is base plus signed 16-bit offset; only its two low bits enter here. All outputs are registered and appear one clock after the inputs.

Top module: `lsa_unit`

## Requirements
- R1: While rst_ni is low, wdata_o, be_o, load_data_o and misalign_o are all zero.
- R2: Each output reflects the inputs sampled at the previous rising clock edge. Inputs changed between edges do not show on the outputs until the next edge.
- R3: Operation code 1 (signed byte load) returns the byte at offset a, taken from read data bits [31-8a:24-8a], with bit 7 of that byte copied into bits 31:8.
- R4: Operation code 2 (unsigned byte load) returns the same selected byte with bits 31:8 cleared.
- R5: Operation codes 3 (signed halfword load) and 4 (unsigned halfword load) return read data bits 31:16 for offset 0 and bits 15:0 for offset 2, sign-extended for code 3 and zero-extended for code 4.
- R6: Operation code 5 (word load) at offset 0 returns the whole read word.
- R7: Operation code 8 (byte store) drives register bits 7:0 on all four lanes and sets only be_o bit 3-a for offset a (be_o[3] enables bits 31:24).
- R8: Operation code 9 (halfword store) drives register bits 15:0 on both halves and sets be_o to 4'b1100 at offset 0 and 4'b0011 at offset 2.
- R9: Operation code 10 (word store) at offset 0 drives the register word unchanged and sets be_o to 4'b1111.
- R10: Codes 3, 4 and 9 with address bit 0 set, and codes 5 and 10 with a nonzero offset, set misalign_o, keep be_o at zero and return a zero load result; the store data is still driven as for the aligned case.
- R11: Operation code 6 (upper immediate) returns the immediate in bits 31:16 with bits 15:0 cleared, independent of the offset.
- R12: Any code that is not a store (0 to 6, 7, 11 to 15) leaves be_o zero and wdata_o zero; any code that is neither a load nor upper immediate leaves load_data_o zero; misalign_o is zero for every code not named in R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 4 | Operation code |
| addr_lo_i | input | 2 | Low bits of the effective byte address |
| reg_data_i | input | 32 | Register value to store |
| imm_i | input | 16 | Immediate for upper-immediate load |
| rdata_i | input | 32 | Word read from data memory |
| wdata_o | output | 32 | Lane-steered store data |
| be_o | output | 4 | Byte write enables, bit 3 for bits 31:24 |
| load_data_o | output | 32 | Extended load or upper-immediate result |
| misalign_o | output | 1 | Access offset not aligned to its size |

## Verification
Every operation code, including the unused ones, is tried at all four offsets against two read words and two register values. The read words put bytes and halfwords with both sign bits set and clear on different lanes, so a wrong lane choice, a swapped endianness or a sign taken from the wrong bit each show as a distinct wrong value. The register values differ in every byte, so store replication from the wrong bits is visible on every lane, and the odd and nonzero offsets separate aligned from misaligned handling for halfword and word sizes.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_LB   = 4'd1,
    OP_LBU  = 4'd2,
    OP_LH   = 4'd3,
    OP_LHU  = 4'd4,
    OP_LW   = 4'd5,
    OP_LUI  = 4'd6,
    OP_RSV7 = 4'd7,
    OP_SB   = 4'd8,
    OP_SH   = 4'd9,
    OP_SW   = 4'd10
  } lsa_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } lsa_size_e;

  typedef struct packed {
    logic      is_load;
    logic      is_store;
    logic      is_lui;
    logic      sign_ext;
    lsa_size_e size;
  } lsa_ctrl_t;

endpackage

// File: rtl/lsa_decode.sv
module lsa_decode
  import lsa_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned AW = $clog2(LANES)
) (
  input  logic [3:0]    op_i,
  input  logic [AW-1:0] addr_lo_i,
  output lsa_ctrl_t     ctrl_o,
  output logic          misalign_o
);

  localparam logic [AW-1:0] HALF_MASK = AW'((LANES / 2) - 1);

  always_comb begin
    ctrl_o = '{is_load: 1'b0, is_store: 1'b0, is_lui: 1'b0,
               sign_ext: 1'b0, size: SZ_BYTE};
    case (op_i)
      OP_LB:  begin ctrl_o.is_load = 1'b1; ctrl_o.sign_ext = 1'b1; end
      OP_LBU: ctrl_o.is_load = 1'b1;
      OP_LH:  begin ctrl_o.is_load = 1'b1; ctrl_o.sign_ext = 1'b1; ctrl_o.size = SZ_HALF; end
      OP_LHU: begin ctrl_o.is_load = 1'b1; ctrl_o.size = SZ_HALF; end
      OP_LW:  begin ctrl_o.is_load = 1'b1; ctrl_o.size = SZ_WORD; end
      OP_LUI: ctrl_o.is_lui = 1'b1;
      OP_SB:  ctrl_o.is_store = 1'b1;
      OP_SH:  begin ctrl_o.is_store = 1'b1; ctrl_o.size = SZ_HALF; end
      OP_SW:  begin ctrl_o.is_store = 1'b1; ctrl_o.size = SZ_WORD; end
      default: ;
    endcase
  end

  always_comb begin
    misalign_o = 1'b0;
    if (ctrl_o.is_load || ctrl_o.is_store) begin
      unique case (ctrl_o.size)
        SZ_HALF: misalign_o = |(addr_lo_i & HALF_MASK);
        SZ_WORD: misalign_o = |addr_lo_i;
        default: misalign_o = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/lsa_store_steer.sv
module lsa_store_steer
  import lsa_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES  = DATA_W / 8,
  localparam int unsigned HALF_W = DATA_W / 2,
  localparam int unsigned AW     = $clog2(LANES)
) (
  input  lsa_ctrl_t         ctrl_i,
  input  logic              misalign_i,
  input  logic [AW-1:0]     addr_lo_i,
  input  logic [DATA_W-1:0] reg_data_i,
  output logic [DATA_W-1:0] wdata_o,
  output logic [LANES-1:0]  be_o
);

  logic [DATA_W-1:0] byte_rep;
  logic [DATA_W-1:0] half_rep;
  logic [LANES-1:0]  lane_hit;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign byte_rep[g*8 +: 8] = reg_data_i[7:0];
    // big-endian: lane g holds bits [DATA_W-1-8g -: 8], enable bit LANES-1-g
    always_comb begin
      unique case (ctrl_i.size)
        SZ_BYTE: lane_hit[g] = (addr_lo_i == AW'(g));
        SZ_HALF: lane_hit[g] = (addr_lo_i[AW-1] == (g >= LANES / 2));
        default: lane_hit[g] = 1'b1;
      endcase
    end
    assign be_o[LANES-1-g] = ctrl_i.is_store & ~misalign_i & lane_hit[g];
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign half_rep[h*HALF_W +: HALF_W] = reg_data_i[HALF_W-1:0];
  end

  always_comb begin
    wdata_o = '0;
    if (ctrl_i.is_store) begin
      unique case (ctrl_i.size)
        SZ_BYTE: wdata_o = byte_rep;
        SZ_HALF: wdata_o = half_rep;
        default: wdata_o = reg_data_i;
      endcase
    end
  end

endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
  import lsa_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 16,
  localparam int unsigned LANES  = DATA_W / 8,
  localparam int unsigned HALF_W = DATA_W / 2,
  localparam int unsigned AW     = $clog2(LANES)
) (
  input  lsa_ctrl_t         ctrl_i,
  input  logic              misalign_i,
  input  logic [AW-1:0]     addr_lo_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] load_data_o
);

  logic [7:0]        lane_byte [LANES];
  logic [7:0]        sel_byte;
  logic [HALF_W-1:0] sel_half;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_byte[g] = rdata_i[DATA_W-1-8*g -: 8];
  end

  assign sel_byte = lane_byte[addr_lo_i];
  assign sel_half = addr_lo_i[AW-1] ? rdata_i[HALF_W-1:0] : rdata_i[DATA_W-1:HALF_W];

  always_comb begin
    load_data_o = '0;
    if (ctrl_i.is_lui) begin
      load_data_o = {imm_i, {(DATA_W-IMM_W){1'b0}}};
    end else if (ctrl_i.is_load && !misalign_i) begin
      unique case (ctrl_i.size)
        SZ_BYTE: load_data_o = {{(DATA_W-8){ctrl_i.sign_ext & sel_byte[7]}}, sel_byte};
        SZ_HALF: load_data_o = {{(DATA_W-HALF_W){ctrl_i.sign_ext & sel_half[HALF_W-1]}}, sel_half};
        default: load_data_o = rdata_i;
      endcase
    end
  end

endmodule

// File: rtl/lsa_unit.sv
module lsa_unit
  import lsa_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 16,
  localparam int unsigned LANES = DATA_W / 8,
  localparam int unsigned AW    = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        op_i,
  input  logic [AW-1:0]     addr_lo_i,
  input  logic [DATA_W-1:0] reg_data_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] wdata_o,
  output logic [LANES-1:0]  be_o,
  output logic [DATA_W-1:0] load_data_o,
  output logic              misalign_o
);

  lsa_ctrl_t         ctrl;
  logic              misalign_d;
  logic [DATA_W-1:0] wdata_d;
  logic [LANES-1:0]  be_d;
  logic [DATA_W-1:0] load_d;

  lsa_decode #(.LANES(LANES)) u_decode (
    .op_i       (op_i),
    .addr_lo_i  (addr_lo_i),
    .ctrl_o     (ctrl),
    .misalign_o (misalign_d)
  );

  lsa_store_steer #(.DATA_W(DATA_W)) u_store (
    .ctrl_i     (ctrl),
    .misalign_i (misalign_d),
    .addr_lo_i  (addr_lo_i),
    .reg_data_i (reg_data_i),
    .wdata_o    (wdata_d),
    .be_o       (be_d)
  );

  lsa_load_extract #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_load (
    .ctrl_i      (ctrl),
    .misalign_i  (misalign_d),
    .addr_lo_i   (addr_lo_i),
    .rdata_i     (rdata_i),
    .imm_i       (imm_i),
    .load_data_o (load_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdata_o     <= '0;
      be_o        <= '0;
      load_data_o <= '0;
      misalign_o  <= 1'b0;
    end else begin
      wdata_o     <= wdata_d;
      be_o        <= be_d;
      load_data_o <= load_d;
      misalign_o  <= misalign_d;
    end
  end

endmodule

// File: rtl/lsa_unit_chk.sv
module lsa_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [3:0]  op_i,
  input logic [1:0]  addr_lo_i,
  input logic [31:0] reg_data_i,
  input logic [15:0] imm_i,
  input logic [31:0] wdata_o,
  input logic [3:0]  be_o,
  input logic [31:0] load_data_o,
  input logic        misalign_o
);

  logic past_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  a_r10_misalign_no_be: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> (be_o == 4'h0) && (load_data_o == 32'h0));

  a_r7_sb_single_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && ($past(op_i) == 4'd8) |-> ($countones(be_o) == 1) && be_o[3 - $past(addr_lo_i)]);

  a_r12_no_be_off_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && ($past(op_i) < 4'd8 || $past(op_i) > 4'd10) |-> (be_o == 4'h0) && (wdata_o == 32'h0));

  a_r11_lui_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && ($past(op_i) == 4'd6) |-> (load_data_o == {$past(imm_i), 16'h0}) && !misalign_o);

  a_r9_sw_full_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && ($past(op_i) == 4'd10) && ($past(addr_lo_i) == 2'd0)
      |-> (be_o == 4'hF) && (wdata_o == $past(reg_data_i)));

  a_r4_lbu_upper_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && ($past(op_i) == 4'd2) |-> (load_data_o[31:8] == 24'h0));

  a_r8_sh_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && ($past(op_i) == 4'd9) && !misalign_o |-> ($countones(be_o) == 2) && (be_o[3] == be_o[2]));

endmodule

bind lsa_unit lsa_unit_chk u_lsa_unit_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .op_i        (op_i),
  .addr_lo_i   (addr_lo_i),
  .reg_data_i  (reg_data_i),
  .imm_i       (imm_i),
  .wdata_o     (wdata_o),
  .be_o        (be_o),
  .load_data_o (load_data_o),
  .misalign_o  (misalign_o)
);

// File: tb/lsa_unit_tb_top.sv
`timescale 1ns/1ps
module lsa_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op = '0;
  logic [1:0]  addr = '0;
  logic [31:0] reg_data = '0;
  logic [15:0] imm = '0;
  logic [31:0] rdata = '0;
  logic [31:0] wdata;
  logic [3:0]  be;
  logic [31:0] load_data;
  logic        misalign;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [31:0] prev_wd = '0, prev_ld = '0;
  logic [3:0]  prev_be = '0;
  logic        prev_mis = 1'b0;

  always #4 clk = ~clk;

  lsa_unit dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .op_i        (op),
    .addr_lo_i   (addr),
    .reg_data_i  (reg_data),
    .imm_i       (imm),
    .rdata_i     (rdata),
    .wdata_o     (wdata),
    .be_o        (be),
    .load_data_o (load_data),
    .misalign_o  (misalign)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s op=%0d a=%0d actual=%h expected=%h", req, what, op, addr, act, exp);
    end
  endtask

  // behavioural reference
  task automatic model(input int o, input int a, input logic [31:0] r, input logic [15:0] im,
                       input logic [31:0] rd, output logic [31:0] wd, output logic [3:0] b,
                       output logic [31:0] ld, output logic mis);
    logic [31:0] by, hw;
    bit is_ld, is_st;
    wd = 0; b = 0; ld = 0;
    is_ld = (o >= 1 && o <= 5);
    is_st = (o >= 8 && o <= 10);
    mis = ((o == 3 || o == 4 || o == 9) && (a % 2) != 0) || ((o == 5 || o == 10) && a != 0);
    by = (rd >> (8 * (3 - a))) & 32'hFF;
    hw = (rd >> (16 * (1 - a / 2))) & 32'hFFFF;
    case (o)
      1: ld = (by >= 128) ? (by | 32'hFFFF_FF00) : by;
      2: ld = by;
      3: ld = (hw >= 32768) ? (hw | 32'hFFFF_0000) : hw;
      4: ld = hw;
      5: ld = rd;
      6: ld = im * 65536;
      8: begin wd = (r & 32'hFF) * 32'h0101_0101; b = 4'b1000 >> a; end
      9: begin wd = (r & 32'hFFFF) * 32'h0001_0001; b = 4'b0011 << (2 * (1 - a / 2)); end
      10: begin wd = r; b = 4'hF; end
      default: ;
    endcase
    if (mis) begin b = 0; if (is_ld) ld = 0; end
    if (!is_st) wd = 0;
  endtask

  function automatic string tag_of(int o, int a);
    bit mis = ((o == 3 || o == 4 || o == 9) && (a % 2) != 0) || ((o == 5 || o == 10) && a != 0);
    if (mis) return "R10";
    case (o)
      1: return "R3";
      2: return "R4";
      3, 4: return "R5";
      5: return "R6";
      6: return "R11";
      8: return "R7";
      9: return "R8";
      10: return "R9";
      default: return "R12";
    endcase
  endfunction

  task automatic step(int o, int a, logic [31:0] r, logic [15:0] im, logic [31:0] rd);
    logic [31:0] ewd, eld;
    logic [3:0]  ebe;
    logic        emis;
    string       t, ts, tl;
    op = 4'(o); addr = 2'(a); reg_data = r; imm = im; rdata = rd;
    #1;
    // R2: nothing moves before the edge
    chk("R2", "hold_ld", load_data, prev_ld);
    chk("R2", "hold_be", {28'h0, be}, {28'h0, prev_be});
    model(o, a, r, im, rd, ewd, ebe, eld, emis);
    @(posedge clk);
    @(negedge clk);
    t  = tag_of(o, a);
    ts = (o >= 8 && o <= 10) ? t : "R12";
    tl = ((o >= 1 && o <= 6)) ? t : "R12";
    chk(ts, "wdata", wdata, ewd);
    chk(ts, "be", {28'h0, be}, {28'h0, ebe});
    chk(tl, "load", load_data, eld);
    chk(emis ? "R10" : "R12", "misalign", {31'h0, misalign}, {31'h0, emis});
    prev_wd = ewd; prev_be = ebe; prev_ld = eld; prev_mis = emis;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rds [2];
    logic [31:0] regs [2];
    rds[0] = 32'h80FF_7F01; rds[1] = 32'h1281_F0A5;
    regs[0] = 32'hC3A5_8E17; regs[1] = 32'h5A96_2DF0;
    op = 4'd10; reg_data = 32'hFFFF_FFFF; imm = 16'hFFFF; rdata = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset holds everything at zero
    chk("R1", "wdata", wdata, 32'h0);
    chk("R1", "be", {28'h0, be}, 32'h0);
    chk("R1", "load", load_data, 32'h0);
    chk("R1", "misalign", {31'h0, misalign}, 32'h0);
    rst_ni = 1'b1;
    op = 4'd0;
    @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < 2; p++) begin
      for (int o = 0; o < 16; o++) begin
        for (int a = 0; a < 4; a++) begin
          step(o, a, regs[p], 16'hA5C3 ^ 16'(o * 257 + a), rds[p]);
        end
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule